// File: doc/BRIEF.md
# Lane-Partitioned Unsigned Comparator

This block compares two unsigned operands that are cut into a fixed number of equal-width lanes. A vector of boundary bits, one per gap between neighbouring lanes, decides at run time which lanes are joined into wider elements. One datapath handles many element layouts. For example, a 24-bit word can be treated as three bytes, a byte beside a 16-bit halfword, or one 24-bit value.

Each lane first works out whether its two slices are equal and whether the slice of `a` is larger. A single ripple network then joins these flags across the lanes of each element. Two internal control bits steer that network: the value fed in at the bottom of an element, and an enable on the greater-than flags. With these two bits the same network gives equality, greater-than or greater-or-equal. Each element's answer is placed on the output bit of its most significant lane. The block is purely combinational.

Top module: `part_cmp_top`

## Requirements
- R1: With `opcode` 2'b00 (equality), the result bit of an element is 1 exactly when every lane of that element holds equal slices of `a` and `b`.
- R2: With `opcode` 2'b01 (greater-than), the result bit of an element is 1 exactly when the unsigned value of `a` over that element is strictly larger than that of `b`.
- R3: With `opcode` 2'b10 (greater-or-equal), the result bit of an element is 1 exactly when the unsigned value of `a` over that element is larger than or equal to that of `b`.
- R4: With `opcode` 2'b11, every result bit is 0 for any operands and any gate setting.
- R5: `gate[i]` lies between lane i and lane i+1. A value of 1 splits the two lanes and 0 joins them. Lane 0 holds bits [LANE_W-1:0]. A joined element is read as one unsigned number in which higher lane indices are more significant.
- R6: An element's result is placed on `result[k]`, where k is its highest lane. The result bits of its lower lanes are 0 for every opcode.
- R7: With all gate bits 0, `result[LANES-1]` carries the comparison of the whole width and all other bits are 0.
- R8: With all gate bits 1, `result[i]` is the comparison of lane i alone, independent of every other lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | LANES*LANE_W | First operand, compared as unsigned |
| b | input | LANES*LANE_W | Second operand, compared as unsigned |
| gate | input | LANES-1 | Per-boundary split (1) or join (0) bits |
| opcode | input | 2 | 00 equal, 01 greater-than, 10 greater-or-equal, 11 off |
| result | output | LANES | One result per element, placed on the element's top lane |

## Verification
Two things always act on the same output vector at once: the ripple of lane flags inside an element, and the zeroing of the bits below that element's top lane. The bench applies every gate pattern under every opcode. It uses operands that are equal, that differ in one chosen lane only, that are extreme, or that match in the upper lane but differ below. In these cases a lower lane would produce a nonzero flag that must be hidden, while the top bit must still reflect it through the chain. Each result vector is compared whole against a reference model that slices and joins the operands arithmetically, so a wrong top bit and a leaked lower bit are both caught in the same cycle.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

   typedef enum logic [1:0] {
      OP_EQ   = 2'b00,
      OP_GT   = 2'b01,
      OP_GE   = 2'b10,
      OP_NONE = 2'b11
   } cmp_op_e;

   typedef struct packed {
      logic valid;    // opcode selects a real comparison
      logic inject;   // constant entering the bottom of each element
      logic gt_en;    // greater-than flags take part in the chain
   } chain_ctl_t;

endpackage

// File: rtl/cmp_lane_flags.sv
module cmp_lane_flags #(
   parameter int LANES  = 3,
   parameter int LANE_W = 8,
   localparam int TOTAL_W = LANES * LANE_W
) (
   input  logic [TOTAL_W-1:0] a,
   input  logic [TOTAL_W-1:0] b,
   output logic [LANES-1:0]   lane_eq,
   output logic [LANES-1:0]   lane_gt
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_eq[i] = (a[i*LANE_W +: LANE_W] == b[i*LANE_W +: LANE_W]);
      assign lane_gt[i] = (a[i*LANE_W +: LANE_W] >  b[i*LANE_W +: LANE_W]);

      // A lane cannot be both equal and larger (feeds R2/R3 chaining)
      always_comb begin
         assert_flags_exclusive_R2: assert (!(lane_eq[i] && lane_gt[i]))
            else $error("lane %0d flagged both equal and greater", i);
      end
   end

endmodule

// File: rtl/cmp_op_decode.sv
module cmp_op_decode
   import cmp_pkg::*;
(
   input  logic [1:0]  opcode,
   output chain_ctl_t  ctl
);

   always_comb begin
      ctl = '{valid: 1'b0, inject: 1'b0, gt_en: 1'b0};
      unique case (cmp_op_e'(opcode))
         OP_EQ:   ctl = '{valid: 1'b1, inject: 1'b1, gt_en: 1'b0};
         OP_GT:   ctl = '{valid: 1'b1, inject: 1'b0, gt_en: 1'b1};
         OP_GE:   ctl = '{valid: 1'b1, inject: 1'b1, gt_en: 1'b1};
         default: ctl = '{valid: 1'b0, inject: 1'b0, gt_en: 1'b0};
      endcase
   end

endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
   import cmp_pkg::*;
#(
   parameter int LANES = 3
) (
   input  chain_ctl_t       ctl,
   input  logic [LANES-1:0] lane_eq,
   input  logic [LANES-1:0] lane_gt,
   input  logic [LANES-2:0] gate,
   output logic [LANES-1:0] result
);

   // Ripple from the lowest lane of each element up to its top lane:
   // acc = gt & en | eq & (lane below, or injected constant at the bottom)
   for (genvar i = 0; i < LANES; i++) begin : g_node
      logic is_low;
      logic is_top;
      logic below;
      logic acc;

      if (i == 0) begin : g_first
         assign is_low = 1'b1;
         assign below  = ctl.inject;
      end else begin : g_rest
         assign is_low = gate[i-1];
         assign below  = is_low ? ctl.inject : g_node[i-1].acc;
      end

      if (i == LANES - 1) begin : g_last
         assign is_top = 1'b1;
      end else begin : g_inner
         assign is_top = gate[i];
      end

      assign acc       = (lane_gt[i] & ctl.gt_en) | (lane_eq[i] & below);
      assign result[i] = ctl.valid & is_top & acc;
   end

endmodule

// File: rtl/part_cmp_top.sv
module part_cmp_top
   import cmp_pkg::*;
#(
   parameter int LANES  = 3,
   parameter int LANE_W = 8,
   localparam int TOTAL_W = LANES * LANE_W
) (
   input  logic [TOTAL_W-1:0] a,
   input  logic [TOTAL_W-1:0] b,
   input  logic [LANES-2:0]   gate,
   input  logic [1:0]         opcode,
   output logic [LANES-1:0]   result
);

   if (LANES < 2) begin : g_bad_lanes
      $error("part_cmp_top: LANES must be at least 2");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("part_cmp_top: LANE_W must be at least 1");
   end

   logic [LANES-1:0] lane_eq;
   logic [LANES-1:0] lane_gt;
   chain_ctl_t       ctl;

   cmp_lane_flags #(.LANES(LANES), .LANE_W(LANE_W)) u_flags (
      .a       (a),
      .b       (b),
      .lane_eq (lane_eq),
      .lane_gt (lane_gt)
   );

   cmp_op_decode u_decode (
      .opcode (opcode),
      .ctl    (ctl)
   );

   cmp_chain #(.LANES(LANES)) u_chain (
      .ctl     (ctl),
      .lane_eq (lane_eq),
      .lane_gt (lane_gt),
      .gate    (gate),
      .result  (result)
   );

   // Port-level checks on the result vector
   always_comb begin
      // R4: the unused opcode produces no result
      if (opcode == 2'b11) begin
         assert_idle_op_R4: assert (result == '0)
            else $error("opcode 11 gave result %b", result);
      end
      // R6: a joined boundary keeps the lower lane's bit low
      for (int i = 0; i < LANES - 1; i++) begin
         if (!gate[i]) begin
            assert_lower_quiet_R6: assert (!result[i])
               else $error("lane %0d below a joined boundary is high", i);
         end
      end
      // R7: whole-width greater-than lands on the top bit
      if (gate == '0 && opcode == 2'b01) begin
         assert_full_gt_R7: assert (result[LANES-1] == (a > b))
            else $error("full-width greater-than wrong");
      end
      // R8: fully split equality is a per-lane compare
      if (&gate && opcode == 2'b00) begin
         for (int i = 0; i < LANES; i++) begin
            assert_split_eq_R8: assert (result[i] ==
               (a[i*LANE_W +: LANE_W] == b[i*LANE_W +: LANE_W]))
               else $error("split equality wrong at lane %0d", i);
         end
      end
   end

endmodule

// File: tb/tb_part_cmp_top.sv
module tb_part_cmp_top;

   localparam int N   = 3;
   localparam int W   = 8;
   localparam int TOT = N * W;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [TOT-1:0] a      = '0;
   logic [TOT-1:0] b      = '0;
   logic [N-2:0]   gate   = '0;
   logic [1:0]     opcode = 2'b11;
   logic [N-1:0]   result;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [N-1:0] exp_q[$];
   string        tag_q[$];

   part_cmp_top #(.LANES(N), .LANE_W(W)) dut (
      .a(a), .b(b), .gate(gate), .opcode(opcode), .result(result)
   );

   // Reference: join lanes arithmetically and compare (R1, R2, R3, R5, R6)
   function automatic logic [N-1:0] model(input logic [TOT-1:0] x,
                                          input logic [TOT-1:0] y,
                                          input logic [N-2:0] g,
                                          input logic [1:0] op);
      logic [N-1:0] r;
      logic [63:0]  m, va, vb;
      int lo;
      r = '0;
      for (int i = 0; i < N; i++) begin
         if (((i == N - 1) || g[i]) && op != 2'b11) begin
            lo = i;
            while (lo > 0 && !g[lo-1]) lo--;
            m  = (64'd1 << ((i - lo + 1) * W)) - 64'd1;
            va = (64'(x) >> (lo * W)) & m;
            vb = (64'(y) >> (lo * W)) & m;
            case (op)
               2'b00:   r[i] = (va == vb);
               2'b01:   r[i] = (va >  vb);
               default: r[i] = (va >= vb);
            endcase
         end
      end
      return r;
   endfunction

   function automatic string tag_of(input logic [N-2:0] g, input logic [1:0] op);
      string t;
      case (op)
         2'b00:   t = "R1";
         2'b01:   t = "R2";
         2'b10:   t = "R3";
         default: t = "R4";
      endcase
      if (op != 2'b11) begin
         if (g == '0)      t = {t, ",R7,R6"};
         else if (&g)      t = {t, ",R8"};
         else              t = {t, ",R5,R6"};
      end
      return t;
   endfunction

   task automatic drive(input logic [TOT-1:0] x, input logic [TOT-1:0] y,
                        input logic [N-2:0] g, input logic [1:0] op);
      @(posedge clk);
      #1;
      a = x; b = y; gate = g; opcode = op;
      exp_q.push_back(model(x, y, g, op));
      tag_q.push_back(tag_of(g, op));
   endtask

   // Monitor: compare away from the active edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [N-1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (result !== e) begin
            errors++;
            $display("FAIL %s: a=%h b=%h gate=%b op=%b actual=%b expected=%b",
                     t, a, b, gate, opcode, result, e);
         end
      end
   end

   function automatic logic [TOT-1:0] rnd();
      return TOT'({$urandom(), $urandom()});
   endfunction

   initial begin
      logic [TOT-1:0] x, y;
      for (int op = 0; op < 4; op++) begin
         for (int g = 0; g < (1 << (N - 1)); g++) begin
            for (int p = 0; p < 9; p++) begin
               x = rnd();
               case (p)
                  0: y = x;                                           // equal
                  1: y = rnd();                                       // random
                  2, 3, 4: y = x ^ (TOT'(1) << ((p - 2) * W + ($urandom() % W))); // one lane differs
                  5: begin x = '1; y = '0; end
                  6: begin x = '0; y = '1; end
                  7: begin y = x; y[W-1:0] = x[W-1:0] - 8'd1; end     // top equal, low larger
                  default: begin y = x; y[W-1:0] = x[W-1:0] + 8'd1; end
               endcase
               drive(x, y, (N-1)'(g), 2'(op));
            end
         end
      end
      // R4 and R8 extra random sweep
      for (int k = 0; k < 200; k++)
         drive(rnd(), rnd(), (N-1)'($urandom()), 2'($urandom()));
      @(posedge clk);
      @(posedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule